// File: doc/BRIEF.md
# Indirect Branch Target Cache

This block predicts the destination of indirect branches. It holds a set-associative table of tagged entries, each with a valid bit, an address tag and a target. The set is chosen by mixing three things: the instruction-aligned branch address, the global direction history, and a short per-thread record of the most recent resolved indirect targets. The last two inputs can each be switched off by a parameter. The lookup port is combinational. Given a branch address, a thread number and the live history, it returns a hit flag and a predicted target in the same cycle.

The update port writes a resolved target into the table on a clock edge. It does not use the live history. It uses the history value that was checkpointed for that branch when it was predicted, so a corrected target goes into the set the branch actually mapped to. The update also shifts the resolved target into that thread's path record.

The set count must be a power of two and at least two. Any other value stops elaboration. The direction history register and the direction predictor are outside this block.

Top module: `itc_top`

## Requirements
- R1: After reset every entry is invalid, so every lookup returns lk_hit = 0 and lk_target = 0.
- R2: A lookup hits when a valid entry in the indexed set has a tag equal to the lookup tag. On a hit, lk_target is that entry's stored target. On a miss, lk_target is 0. At most one way of a set matches.
- R3: The set index is the low log2(SETS) bits of the XOR of three terms. The first is (pc >> ADDR_SHIFT). The second is the zero-extended history, included when USE_GHR = 1. The third is the XOR of every path-record target shifted right by ADDR_SHIFT, included when USE_PATH = 1. The tag is the low TAG_W bits of (pc >> ADDR_SHIFT).
- R4: An update computes its set index from up_ghr, the checkpointed history. The lookup history lk_ghr has no effect on where a write lands.
- R5: If a valid entry in the update's set already carries the update tag, only that entry's target is rewritten. The set's replacement pointer is left unchanged.
- R6: If no tag matches on an update, the way named by the set's round-robin pointer is filled and marked valid. The pointer then advances by one and wraps from WAYS-1 to 0. Every pointer is 0 after reset.
- R7: Each update shifts up_target into position 0 of thread up_tid's path record, and the entry at position PATH_LEN-1 is dropped. The update's own index uses the record as it was before the shift. Other threads' records and all lookups leave a record unchanged. Records reset to 0.
- R8: While up_valid = 0, no table entry, pointer or path record changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Lookup branch address |
| lk_tid | input | max(1,log2 THREADS) | Lookup thread number |
| lk_ghr | input | GHR_W | Live global history for the lookup |
| lk_hit | output | 1 | Lookup found a matching entry |
| lk_target | output | PC_W | Predicted target, 0 on a miss |
| up_valid | input | 1 | Update strobe |
| up_pc | input | PC_W | Branch address being updated |
| up_tid | input | max(1,log2 THREADS) | Thread of the updated branch |
| up_ghr | input | GHR_W | History checkpointed when the branch was predicted |
| up_target | input | PC_W | Resolved target |

## Verification
The bench builds the cache with 16 sets, 2 ways, 2 threads, a 3-deep path record, a 13-bit history and a 2-bit alignment shift, with both history and path mixing turned on. With only 16 sets, the bench can compute a history value that steers any address into any chosen set. That lets it make three addresses alias into one set, which exposes eviction order, in-place rewrites and pointer wrap-around within a few updates. With 2 ways, each update that misses on its tag flips the pointer, so a pointer that advances on an in-place rewrite evicts the wrong entry and shows up as a lost hit. With 2 threads, a path record that leaks from one thread into the other shows up as a lookup landing in the wrong set.

// File: rtl/itc_pkg.sv
package itc_pkg;

  // Width of an index over n items, never below one bit.
  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic bit is_pow2(int unsigned n);
    return (n != 0) && ((n & (n - 1)) == 0);
  endfunction

endpackage

// File: rtl/itc_index.sv
module itc_index #(
  parameter int PC_W       = 32,
  parameter int ADDR_SHIFT = 2,
  parameter int GHR_W      = 13,
  parameter int PATH_LEN   = 3,
  parameter int IDX_W      = 6,
  parameter int TAG_W      = 16,
  parameter bit USE_GHR    = 1'b1,
  parameter bit USE_PATH   = 1'b1
) (
  input  logic [PC_W-1:0]                pc,
  input  logic [GHR_W-1:0]               ghr,
  input  logic [PATH_LEN-1:0][PC_W-1:0]  path,
  output logic [IDX_W-1:0]               idx,
  output logic [TAG_W-1:0]               tag
);
  localparam int SPC_W = PC_W - ADDR_SHIFT;

  // Aligned address mixed with history and with the folded path targets.
  function automatic logic [SPC_W-1:0] mix(
    input logic [PC_W-1:0]               a,
    input logic [GHR_W-1:0]              h,
    input logic [PATH_LEN-1:0][PC_W-1:0] p
  );
    logic [SPC_W-1:0] acc;
    acc = a[PC_W-1:ADDR_SHIFT];
    if (USE_GHR) acc = acc ^ SPC_W'(h);
    if (USE_PATH) begin
      for (int i = 0; i < PATH_LEN; i++) acc = acc ^ p[i][PC_W-1:ADDR_SHIFT];
    end
    return acc;
  endfunction

  logic [SPC_W-1:0] mixed;
  logic [SPC_W-1:0] spc;
  logic             unused_bits;

  always_comb begin
    mixed = mix(pc, ghr, path);
    spc   = pc[PC_W-1:ADDR_SHIFT];
    idx   = mixed[IDX_W-1:0];
    tag   = spc[TAG_W-1:0];
  end

  assign unused_bits = ^{pc, mixed};
endmodule

// File: rtl/itc_path_hist.sv
module itc_path_hist #(
  parameter int THREADS  = 2,
  parameter int PATH_LEN = 3,
  parameter int TGT_W    = 32,
  parameter int TID_W    = 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [TID_W-1:0]               push_tid,
  input  logic [TGT_W-1:0]               push_tgt,
  input  logic [TID_W-1:0]               rd_tid_a,
  output logic [PATH_LEN-1:0][TGT_W-1:0] rd_a,
  input  logic [TID_W-1:0]               rd_tid_b,
  output logic [PATH_LEN-1:0][TGT_W-1:0] rd_b
);
  logic [THREADS-1:0][PATH_LEN-1:0][TGT_W-1:0] hist;
  logic push_ok;

  assign push_ok = push && (int'(push_tid) < THREADS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
    end else if (push_ok) begin
      for (int i = PATH_LEN - 1; i > 0; i--) hist[push_tid][i] <= hist[push_tid][i-1];
      hist[push_tid][0] <= push_tgt;
    end
  end

  always_comb begin
    rd_a = (int'(rd_tid_a) < THREADS) ? hist[rd_tid_a] : '0;
    rd_b = (int'(rd_tid_b) < THREADS) ? hist[rd_tid_b] : '0;
  end

  // R7: the newest slot holds the pushed target one edge later
  assert_path_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> hist[$past(push_tid)][0] == $past(push_tgt));

  // R8: without a push the record does not move
  assert_path_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> $stable(hist));
endmodule

// File: rtl/itc_way_store.sv
module itc_way_store #(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int IDX_W = 6,
  parameter int TAG_W = 16,
  parameter int TGT_W = 32,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [TGT_W-1:0] lk_target,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TGT_W-1:0] wr_tgt
);
  logic [SETS-1:0][WAYS-1:0]  vld;
  logic [SETS-1:0][WAY_W-1:0] rr;
  logic [TAG_W-1:0]           tags [SETS][WAYS];
  logic [TGT_W-1:0]           tgts [SETS][WAYS];

  // Named internal events used by the assertions.
  logic [WAYS-1:0]  lk_match;
  logic [WAYS-1:0]  wr_match;
  logic             wr_hit;
  logic [WAY_W-1:0] wr_hit_way;
  logic [WAY_W-1:0] victim;

  function automatic logic [WAY_W-1:0] rr_next(input logic [WAY_W-1:0] r);
    return (int'(r) == WAYS - 1) ? '0 : WAY_W'(r + 1'b1);
  endfunction

  always_comb begin
    lk_target = '0;
    for (int w = 0; w < WAYS; w++) begin
      lk_match[w] = vld[lk_idx][w] && (tags[lk_idx][w] == lk_tag);
      if (lk_match[w]) lk_target = lk_target | tgts[lk_idx][w];
    end
    lk_hit = |lk_match;
  end

  always_comb begin
    wr_hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      wr_match[w] = vld[wr_idx][w] && (tags[wr_idx][w] == wr_tag);
      if (wr_match[w]) wr_hit_way = WAY_W'(w);
    end
    wr_hit = |wr_match;
    victim = wr_hit ? wr_hit_way : rr[wr_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      rr  <= '0;
    end else if (wr_en) begin
      vld[wr_idx][victim] <= 1'b1;
      if (!wr_hit) rr[wr_idx] <= rr_next(rr[wr_idx]);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tags[wr_idx][victim] <= wr_tag;
      tgts[wr_idx][victim] <= wr_tgt;
    end
  end

  // R2: tags stay unique within a set, so at most one way matches
  assert_lk_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  // R5: an in-place rewrite leaves the pointer alone
  assert_rr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hit) |=> rr[$past(wr_idx)] == $past(rr[wr_idx]));

  // R6: a fill advances the pointer with wrap
  assert_rr_adv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hit) |=> rr[$past(wr_idx)] == rr_next($past(rr[wr_idx])));

  // R6: the written way is valid afterwards
  assert_fill_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld[$past(wr_idx)][$past(victim)]);

  // R8: no write, no change of valid bits or pointers
  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(vld) && $stable(rr)));
endmodule

// File: rtl/itc_top.sv
module itc_top #(
  parameter int PC_W       = 32,
  parameter int SETS       = 64,
  parameter int WAYS       = 4,
  parameter int TAG_W      = 16,
  parameter int PATH_LEN   = 3,
  parameter int ADDR_SHIFT = 2,
  parameter int GHR_W      = 13,
  parameter int THREADS    = 2,
  parameter bit USE_GHR    = 1'b1,
  parameter bit USE_PATH   = 1'b1
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic [PC_W-1:0]                           lk_pc,
  input  logic [itc_pkg::idx_width(THREADS)-1:0]    lk_tid,
  input  logic [GHR_W-1:0]                          lk_ghr,
  output logic                                      lk_hit,
  output logic [PC_W-1:0]                           lk_target,
  input  logic                                      up_valid,
  input  logic [PC_W-1:0]                           up_pc,
  input  logic [itc_pkg::idx_width(THREADS)-1:0]    up_tid,
  input  logic [GHR_W-1:0]                          up_ghr,
  input  logic [PC_W-1:0]                           up_target
);
  localparam int IDX_W = itc_pkg::idx_width(SETS);
  localparam int WAY_W = itc_pkg::idx_width(WAYS);
  localparam int TID_W = itc_pkg::idx_width(THREADS);

  if (!itc_pkg::is_pow2(SETS) || SETS < 2) begin : g_bad_sets
    $error("itc_top: SETS must be a power of two and at least 2");
  end
  if (TAG_W > PC_W - ADDR_SHIFT || IDX_W > PC_W - ADDR_SHIFT || GHR_W > PC_W - ADDR_SHIFT) begin : g_bad_width
    $error("itc_top: tag, index or history wider than the aligned address");
  end

  logic [PATH_LEN-1:0][PC_W-1:0] lk_path, up_path;
  logic [IDX_W-1:0]              lk_idx, up_idx;
  logic [TAG_W-1:0]              lk_tag, up_tag;

  itc_path_hist #(
    .THREADS(THREADS), .PATH_LEN(PATH_LEN), .TGT_W(PC_W), .TID_W(TID_W)
  ) u_path (
    .clk(clk), .rst_n(rst_n),
    .push(up_valid), .push_tid(up_tid), .push_tgt(up_target),
    .rd_tid_a(lk_tid), .rd_a(lk_path),
    .rd_tid_b(up_tid), .rd_b(up_path)
  );

  itc_index #(
    .PC_W(PC_W), .ADDR_SHIFT(ADDR_SHIFT), .GHR_W(GHR_W), .PATH_LEN(PATH_LEN),
    .IDX_W(IDX_W), .TAG_W(TAG_W), .USE_GHR(USE_GHR), .USE_PATH(USE_PATH)
  ) u_lk_index (
    .pc(lk_pc), .ghr(lk_ghr), .path(lk_path), .idx(lk_idx), .tag(lk_tag)
  );

  // R4: the write index comes from the checkpointed history only
  itc_index #(
    .PC_W(PC_W), .ADDR_SHIFT(ADDR_SHIFT), .GHR_W(GHR_W), .PATH_LEN(PATH_LEN),
    .IDX_W(IDX_W), .TAG_W(TAG_W), .USE_GHR(USE_GHR), .USE_PATH(USE_PATH)
  ) u_up_index (
    .pc(up_pc), .ghr(up_ghr), .path(up_path), .idx(up_idx), .tag(up_tag)
  );

  itc_way_store #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(PC_W), .WAY_W(WAY_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_target(lk_target),
    .wr_en(up_valid), .wr_idx(up_idx), .wr_tag(up_tag), .wr_tgt(up_target)
  );

  // R2: a miss drives a zero target
  assert_miss_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_target == '0));
endmodule

// File: tb/itc_top_tb.sv
module itc_top_tb;
  localparam int NS = 16, NW = 2, NT = 2, PL = 3;

  logic        clk = 0, rst_n = 0;
  logic [31:0] lk_pc = 0, lk_target, up_pc = 0, up_target = 0;
  logic [0:0]  lk_tid = 0, up_tid = 0;
  logic [12:0] lk_ghr = 0, up_ghr = 0;
  logic        lk_hit, up_valid = 0;

  itc_top #(.PC_W(32), .SETS(NS), .WAYS(NW), .TAG_W(16), .PATH_LEN(PL),
            .ADDR_SHIFT(2), .GHR_W(13), .THREADS(NT), .USE_GHR(1'b1), .USE_PATH(1'b1))
  u_dut (.clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_tid(lk_tid), .lk_ghr(lk_ghr),
         .lk_hit(lk_hit), .lk_target(lk_target), .up_valid(up_valid), .up_pc(up_pc),
         .up_tid(up_tid), .up_ghr(up_ghr), .up_target(up_target));

  always #5 clk = ~clk;

  // Reference model state
  bit          m_vld [NS][NW];
  logic [15:0] m_tag [NS][NW];
  logic [31:0] m_tgt [NS][NW];
  int          m_rr  [NS];
  logic [31:0] m_path [NT][PL];

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic int f_idx(logic [31:0] pc, logic [12:0] g, int tid);
    logic [31:0] acc;
    acc = (pc >> 2) ^ {19'd0, g};
    for (int i = 0; i < PL; i++) acc = acc ^ (m_path[tid][i] >> 2);
    return int'(acc % NS);
  endfunction

  function automatic logic [15:0] f_tag(logic [31:0] pc);
    return 16'((pc >> 2) & 32'hffff);
  endfunction

  // History value that steers pc of thread tid into set s
  function automatic logic [12:0] aim(logic [31:0] pc, int tid, int s);
    int base;
    base = f_idx(pc, 13'd0, tid);
    return {9'($urandom), 4'(s ^ base)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(string req, logic [31:0] pc, int tid, logic [12:0] g);
    int s;
    logic eh;
    logic [31:0] et;
    @(negedge clk);
    lk_pc = pc; lk_tid = 1'(tid); lk_ghr = g;
    #1;
    s = f_idx(pc, g, tid); eh = 0; et = 0;
    for (int w = 0; w < NW; w++)
      if (m_vld[s][w] && m_tag[s][w] == f_tag(pc)) begin eh = 1; et = m_tgt[s][w]; end
    check({req, " hit"}, {31'd0, lk_hit}, {31'd0, eh});
    check({req, " target"}, lk_target, et);
  endtask

  task automatic upd(logic [31:0] pc, int tid, logic [12:0] g, logic [31:0] tgt);
    int s, v;
    bit hit;
    @(negedge clk);
    up_pc = pc; up_tid = 1'(tid); up_ghr = g; up_target = tgt; up_valid = 1;
    lk_pc = $urandom; lk_ghr = 13'($urandom); // lookup side must not matter (R4)
    @(posedge clk);
    s = f_idx(pc, g, tid); hit = 0; v = 0;
    for (int w = 0; w < NW; w++)
      if (m_vld[s][w] && m_tag[s][w] == f_tag(pc)) begin hit = 1; v = w; end
    if (!hit) begin v = m_rr[s]; m_rr[s] = (v == NW - 1) ? 0 : v + 1; end
    m_vld[s][v] = 1; m_tag[s][v] = f_tag(pc); m_tgt[s][v] = tgt;
    for (int i = PL - 1; i > 0; i--) m_path[tid][i] = m_path[tid][i-1];
    m_path[tid][0] = tgt;
    @(negedge clk);
    up_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  localparam logic [31:0] PA = 32'h0000_1040, PB = 32'h0000_2080,
                          PC = 32'h0000_30c4, PD = 32'h0000_4a10;
  logic [31:0] pool [6];

  initial begin
    void'($urandom(32'd4242));
    for (int s = 0; s < NS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < NW; w++) begin m_vld[s][w] = 0; m_tag[s][w] = 0; m_tgt[s][w] = 0; end
    end
    for (int t = 0; t < NT; t++) for (int i = 0; i < PL; i++) m_path[t][i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: empty after reset
    look("R1 reset A", PA, 0, 13'h0);
    look("R1 reset B", PB, 1, 13'h1abc);

    // R2/R3: write then hit when steered to the same set, miss elsewhere
    upd(PA, 0, aim(PA, 0, 5), 32'h0000_8000);
    look("R2 hit A", PA, 0, aim(PA, 0, 5));
    look("R3 other set", PA, 0, aim(PA, 0, 6));

    // R5: in-place rewrite keeps pointer; R6: fills and eviction order
    upd(PA, 0, aim(PA, 0, 5), 32'h0000_8100);
    look("R5 rewritten A", PA, 0, aim(PA, 0, 5));
    upd(PB, 0, aim(PB, 0, 5), 32'h0000_9000);
    look("R5 A kept", PA, 0, aim(PA, 0, 5));
    look("R6 B filled", PB, 0, aim(PB, 0, 5));
    upd(PC, 0, aim(PC, 0, 5), 32'h0000_a000);
    look("R6 A evicted", PA, 0, aim(PA, 0, 5));
    look("R6 B survives", PB, 0, aim(PB, 0, 5));
    look("R6 C filled", PC, 0, aim(PC, 0, 5));
    upd(PA, 0, aim(PA, 0, 5), 32'h0000_b000);
    look("R6 wrap evicts B", PB, 0, aim(PB, 0, 5));
    look("R6 wrap A", PA, 0, aim(PA, 0, 5));

    // R4: write goes to the set chosen by the checkpoint history
    begin
      logic [12:0] g_ck;
      g_ck = aim(PD, 1, 9);
      upd(PD, 1, g_ck, 32'h0000_c000);
      look("R4 checkpoint set", PD, 1, aim(PD, 1, 9));
      look("R4 not live set", PD, 1, aim(PD, 1, 12));
    end

    // R7: path record per thread, oldest dropped
    upd(PB, 0, aim(PB, 0, 3), 32'h0001_0000);
    for (int k = 0; k < 4; k++) upd(32'h0000_5000 + 32'(k * 64), 1, 13'($urandom), 32'($urandom));
    look("R7 thread0 path untouched", PB, 0, aim(PB, 0, 3));
    look("R7 thread1 path shifted", PD, 1, aim(PD, 1, 9));

    // R8: update pins wiggle with strobe low
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      up_valid = 0; up_pc = $urandom; up_tid = 1'($urandom); up_ghr = 13'($urandom); up_target = $urandom;
    end
    look("R8 B stable", PB, 0, aim(PB, 0, 3));
    look("R8 A stable", PA, 0, aim(PA, 0, 5));
    look("R8 D stable", PD, 1, aim(PD, 1, 9));

    // Random mix over a small aliasing pool
    pool[0] = PA; pool[1] = PB; pool[2] = PC; pool[3] = PD;
    pool[4] = 32'h0000_7004; pool[5] = 32'h0001_2348;
    for (int it = 0; it < 600; it++) begin
      logic [31:0] pc;
      int tid;
      logic [12:0] g;
      pc = pool[$urandom % 6]; tid = int'($urandom % NT);
      g = ($urandom % 2 == 0) ? aim(pc, tid, int'($urandom % 4)) : 13'($urandom);
      if ($urandom % 3 == 0) upd(pc, tid, g, $urandom);
      else look("R2 R3 R6 random", pc, tid, g);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule